// File: doc/BRIEF.md
# I2C Register Target with Alert Response

This block gives a host processor register access to a power-sourcing port controller over a two-wire I2C bus at up to 1 MHz. It oversamples SCL and SDA with the system clock. Both lines pass through a two-flop synchronizer and a run-length deglitch filter before START, STOP and edge detection. On the device side it has a single-port register-file interface: a pointer, write data, a one-cycle write strobe, and read data that the register file returns combinationally.

Three host transactions are served. A register write sends the device address, a pointer byte and one or more data bytes. A register read loads the pointer, then reads with a repeated START. A short-form read addresses the device with no pointer loaded and receives the interrupt status byte. While the interrupt input is active, the block also answers the bus-wide alert-response read and returns its own address. It gives way if another device wins the wired-AND arbitration. An inactivity watchdog returns the interface to idle when a transaction stalls and sets a sticky flag.

Top module: `pse_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits are binary 010 followed by devPins[3:0] (most significant pin first). A START, including a repeated START, always leaves SDA released.
- R2: In a write (R/W bit 0), the target acknowledges the pointer byte and every data byte. Each data byte produces exactly one single-cycle regWe pulse, with regWdata holding the byte and regAddr holding the pointer.
- R3: The pointer advances by one after every data byte written and after every register byte loaded for transmission.
- R4: A read (R/W bit 1) issued through a repeated START after a pointer write returns the register at the pointer, most significant bit first. SDA changes only while SCL is low. The master's acknowledge continues with the next register, and a not-acknowledge ends the transfer.
- R5: A read with no pointer loaded since the last STOP returns intStatus for every byte. A STOP discards a loaded pointer.
- R6: A read to alert-response address 0001100 is acknowledged only while alertActive is 1. The target then returns {010, devPins, 1}.
- R7: While sending its alert-response byte, the target stops driving SDA for the rest of the byte as soon as it samples a 0 on a bit where it released the line.
- R8: If the filtered SCL and SDA do not change for WD_CYCLES clocks during a transaction, the target releases SDA, returns to idle and sets busLost. busLost stays set until reset.
- R9: For any other address, the target neither acknowledges nor writes to the register file until the next START or STOP.
- R10: During and after reset, SDA is released, regWe is 0 and busLost is 0.
- R11: Pulses on SCL or SDA that last fewer than FILT_LEN clocks after synchronization have no effect on the transferred data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| sdaDriveLow | output | 1 | 1 pulls SDA low (open-drain enable) |
| devPins | input | 4 | Low four bits of the device address |
| alertActive | input | 1 | Interrupt output currently asserted |
| intStatus | input | 8 | Interrupt register contents |
| regAddr | output | 8 | Register pointer |
| regWdata | output | 8 | Write data for the register file |
| regWe | output | 1 | One-cycle register write strobe |
| regRdata | input | 8 | Register file read data at regAddr |
| busLost | output | 1 | Sticky watchdog expiry flag |

## Verification
On every cycle, the checker confirms four things: SDA is only pulled low while the filtered SCL is low; write strobes last one cycle; each pointer step adds exactly one; and START or watchdog expiry leaves SDA released with busLost held. Only the bench scenarios can show the byte-level results. These are the address match across all sixteen pin settings, auto-incremented writes and reads, the interrupt byte on short-form reads, the alert-response byte and its loss of arbitration, glitch rejection inside a data byte, and recovery after a stalled acknowledge.

// File: rtl/pse_i2c_pkg.sv
package pse_i2c_pkg;
  localparam int BYTE_W = 8;
  localparam int PIN_W  = 4;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [2:0] DEV_PREFIX = 3'b010;
  localparam logic [6:0] ARA_ADDR   = 7'b0001100;

  typedef enum logic [1:0] {TX_REG, TX_INT, TX_OWN} txSrc_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_ARA_ACK, ST_PTR, ST_PTR_ACK,
    ST_WDATA, ST_WDATA_ACK, ST_TX, ST_MACK, ST_ARA_TX, ST_IGNORE
  } state_e;

  typedef struct packed {
    logic   clrBits;
    logic   sampleBit;
    logic   loadTx;
    txSrc_e txSel;
    logic   shiftTx;
    logic   loadPtr;
    logic   incPtr;
    logic   wrReg;
    logic   setPtrValid;
    logic   clrPtrValid;
  } dpStrobe_t;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    syncQ;
  logic [CW-1:0] runCnt;
  logic          filtQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ  <= 2'b11;
      runCnt <= '0;
      filtQ  <= 1'b1;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      if (syncQ[1] == filtQ) begin
        runCnt <= '0;
      end else if (runCnt == CW'(FILT_LEN - 1)) begin
        filtQ  <= syncQ[1];
        runCnt <= '0;
      end else begin
        runCnt <= runCnt + 1'b1;
      end
    end
  end

  assign filtOut = filtQ;
endmodule

// File: rtl/i2c_target_dp.sv
module i2c_target_dp
  import pse_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclF,
  input  logic              sdaF,
  input  logic [PIN_W-1:0]  devPins,
  input  logic [BYTE_W-1:0] regRdata,
  input  logic [BYTE_W-1:0] intStatus,
  input  dpStrobe_t         strobe,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              lineEdge,
  output logic              byteDone,
  output logic              addrMine,
  output logic              addrAra,
  output logic              rwBit,
  output logic              txBit,
  output logic              ptrValid,
  output logic [BYTE_W-1:0] regAddr,
  output logic [BYTE_W-1:0] regWdata
);
  logic              sclPrev, sdaPrev;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift, ptrQ;
  logic              ptrValidQ;
  logic [BYTE_W-1:0] ownByte;

  assign ownByte = {DEV_PREFIX, devPins, 1'b1};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  assign sclRise  = sclF & ~sclPrev;
  assign sclFall  = ~sclF & sclPrev;
  assign startDet = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopDet  = sclF & sclPrev & ~sdaPrev & sdaF;
  assign lineEdge = (sclF ^ sclPrev) | (sdaF ^ sdaPrev);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
    end else if (strobe.clrBits) begin
      bitCnt <= '0;
    end else if (strobe.sampleBit) begin
      bitCnt  <= bitCnt + 1'b1;
      rxShift <= {rxShift[BYTE_W-2:0], sdaF};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (strobe.loadTx) begin
      case (strobe.txSel)
        TX_REG:  txShift <= regRdata;
        TX_INT:  txShift <= intStatus;
        default: txShift <= ownByte;
      endcase
    end else if (strobe.shiftTx) begin
      txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ      <= '0;
      ptrValidQ <= 1'b0;
    end else begin
      if (strobe.loadPtr)     ptrQ <= rxShift;
      else if (strobe.incPtr) ptrQ <= ptrQ + 1'b1;
      if (strobe.clrPtrValid)      ptrValidQ <= 1'b0;
      else if (strobe.setPtrValid) ptrValidQ <= 1'b1;
    end
  end

  assign byteDone = (bitCnt == CNT_W'(BYTE_W));
  assign addrMine = (rxShift[BYTE_W-1:1] == {DEV_PREFIX, devPins});
  assign addrAra  = (rxShift[BYTE_W-1:1] == ARA_ADDR);
  assign rwBit    = rxShift[0];
  assign txBit    = txShift[BYTE_W-1];
  assign ptrValid = ptrValidQ;
  assign regAddr  = ptrQ;
  assign regWdata = rxShift;
endmodule

// File: rtl/i2c_target_ctrl.sv
module i2c_target_ctrl
  import pse_i2c_pkg::*;
#(
  parameter int WD_CYCLES = 100_000_000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclRise,
  input  logic      sclFall,
  input  logic      startDet,
  input  logic      stopDet,
  input  logic      lineEdge,
  input  logic      byteDone,
  input  logic      addrMine,
  input  logic      addrAra,
  input  logic      rwBit,
  input  logic      txBit,
  input  logic      ptrValid,
  input  logic      sdaF,
  input  logic      alertActive,
  output dpStrobe_t strobe,
  output logic      sdaDriveLow,
  output logic      busLost,
  output logic      wdExpire
);
  localparam int WD_W = $clog2(WD_CYCLES + 1);

  state_e    st, stN;
  txSrc_e    srcQ, srcN;
  logic      ackQ, ackN;
  logic      lostQ;
  logic [WD_W-1:0] wdCnt;
  dpStrobe_t sN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wdCnt <= '0;
      lostQ <= 1'b0;
    end else begin
      if (st == ST_IDLE || lineEdge) wdCnt <= '0;
      else                           wdCnt <= wdCnt + 1'b1;
      if (wdExpire) lostQ <= 1'b1;
    end
  end

  assign wdExpire = (st != ST_IDLE) && !lineEdge && (wdCnt == WD_W'(WD_CYCLES - 1));
  assign busLost  = lostQ;

  always_comb begin
    stN      = st;
    srcN     = srcQ;
    ackN     = ackQ;
    sN       = '0;
    sN.txSel = srcQ;
    if (wdExpire || stopDet) begin
      stN            = ST_IDLE;
      sN.clrPtrValid = 1'b1;
    end else if (startDet) begin
      stN        = ST_ADDR;
      sN.clrBits = 1'b1;
    end else begin
      case (st)
        ST_ADDR: begin
          if (sclRise) sN.sampleBit = 1'b1;
          else if (sclFall && byteDone) begin
            if (addrMine)                           stN = ST_ADDR_ACK;
            else if (addrAra && rwBit && alertActive) stN = ST_ARA_ACK;
            else                                    stN = ST_IGNORE;
          end
        end
        ST_ADDR_ACK: if (sclFall) begin
          sN.clrBits = 1'b1;
          if (!rwBit) stN = ST_PTR;
          else begin
            srcN      = ptrValid ? TX_REG : TX_INT;
            sN.loadTx = 1'b1;
            sN.txSel  = srcN;
            sN.incPtr = ptrValid;
            stN       = ST_TX;
          end
        end
        ST_ARA_ACK: if (sclFall) begin
          sN.clrBits = 1'b1;
          sN.loadTx  = 1'b1;
          sN.txSel   = TX_OWN;
          stN        = ST_ARA_TX;
        end
        ST_PTR: begin
          if (sclRise) sN.sampleBit = 1'b1;
          else if (sclFall && byteDone) begin
            sN.loadPtr     = 1'b1;
            sN.setPtrValid = 1'b1;
            stN            = ST_PTR_ACK;
          end
        end
        ST_WDATA: begin
          if (sclRise) sN.sampleBit = 1'b1;
          else if (sclFall && byteDone) begin
            sN.wrReg  = 1'b1;
            sN.incPtr = 1'b1;
            stN       = ST_WDATA_ACK;
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: if (sclFall) begin
          sN.clrBits = 1'b1;
          stN        = ST_WDATA;
        end
        ST_TX: begin
          if (sclRise) sN.sampleBit = 1'b1;
          else if (sclFall) begin
            if (byteDone) begin
              ackN = 1'b0;
              stN  = ST_MACK;
            end else sN.shiftTx = 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) ackN = !sdaF;
          else if (sclFall) begin
            if (ackQ) begin
              sN.clrBits = 1'b1;
              sN.loadTx  = 1'b1;
              sN.txSel   = srcQ;
              sN.incPtr  = (srcQ == TX_REG);
              stN        = ST_TX;
            end else stN = ST_IGNORE;
          end
        end
        ST_ARA_TX: begin
          if (sclRise) begin
            if (txBit && !sdaF) stN = ST_IGNORE;
            else sN.sampleBit = 1'b1;
          end else if (sclFall) begin
            if (byteDone) stN = ST_IGNORE;
            else sN.shiftTx = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= ST_IDLE;
      srcQ <= TX_INT;
      ackQ <= 1'b0;
    end else begin
      st   <= stN;
      srcQ <= srcN;
      ackQ <= ackN;
    end
  end

  assign strobe = sN;

  always_comb begin
    case (st)
      ST_ADDR_ACK, ST_ARA_ACK, ST_PTR_ACK, ST_WDATA_ACK: sdaDriveLow = 1'b1;
      ST_TX, ST_ARA_TX:                                 sdaDriveLow = !txBit;
      default:                                          sdaDriveLow = 1'b0;
    endcase
  end
endmodule

// File: rtl/pse_i2c_target.sv
module pse_i2c_target
  import pse_i2c_pkg::*;
#(
  parameter int FILT_LEN  = 4,
  parameter int WD_CYCLES = 100_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaDriveLow,
  input  logic [3:0] devPins,
  input  logic       alertActive,
  input  logic [7:0] intStatus,
  output logic [7:0] regAddr,
  output logic [7:0] regWdata,
  output logic       regWe,
  input  logic [7:0] regRdata,
  output logic       busLost
);
  logic [1:0] lineRaw, lineFilt;
  logic       sclFilt, sdaFilt;
  logic       sclRise, sclFall, startDet, stopDet, lineEdge;
  logic       byteDone, addrMine, addrAra, rwBit, txBit, ptrValid;
  logic       wdExpire;
  dpStrobe_t  strobes;

  assign lineRaw = {sclIn, sdaIn};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk(clk), .rstN(rstN), .rawIn(lineRaw[g]), .filtOut(lineFilt[g])
    );
  end

  assign sclFilt = lineFilt[1];
  assign sdaFilt = lineFilt[0];

  i2c_target_dp u_dp (
    .clk(clk), .rstN(rstN), .sclF(sclFilt), .sdaF(sdaFilt),
    .devPins(devPins), .regRdata(regRdata), .intStatus(intStatus),
    .strobe(strobes), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .lineEdge(lineEdge),
    .byteDone(byteDone), .addrMine(addrMine), .addrAra(addrAra),
    .rwBit(rwBit), .txBit(txBit), .ptrValid(ptrValid),
    .regAddr(regAddr), .regWdata(regWdata)
  );

  i2c_target_ctrl #(.WD_CYCLES(WD_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .lineEdge(lineEdge),
    .byteDone(byteDone), .addrMine(addrMine), .addrAra(addrAra),
    .rwBit(rwBit), .txBit(txBit), .ptrValid(ptrValid), .sdaF(sdaFilt),
    .alertActive(alertActive), .strobe(strobes), .sdaDriveLow(sdaDriveLow),
    .busLost(busLost), .wdExpire(wdExpire)
  );

  assign regWe = strobes.wrReg;
endmodule

// File: rtl/pse_i2c_target_chk.sv
module pse_i2c_target_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sdaDriveLow,
  input logic       sclFilt,
  input logic       startDet,
  input logic       wdExpire,
  input logic       busLost,
  input logic       regWe,
  input logic [7:0] regAddr,
  input logic       incPtr
);
  assert_start_release_R1: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> !sdaDriveLow);

  assert_we_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    incPtr |=> regAddr == $past(regAddr) + 8'd1);

  assert_drive_on_low_scl_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDriveLow) |-> !sclFilt);

  assert_wd_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    wdExpire |=> !sdaDriveLow);

  assert_lost_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    busLost |=> busLost);
endmodule

bind pse_i2c_target pse_i2c_target_chk u_chk (
  .clk(clk), .rstN(rstN), .sdaDriveLow(sdaDriveLow), .sclFilt(sclFilt),
  .startDet(startDet), .wdExpire(wdExpire), .busLost(busLost),
  .regWe(regWe), .regAddr(regAddr), .incPtr(strobes.incPtr)
);

// File: tb/sim_pse_i2c_target.sv
module sim_pse_i2c_target;
  localparam int Q    = 16;
  localparam int FILT = 4;
  localparam int WD   = 3000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1;
  logic       sdaMlow = 1'b0;
  logic       extLow = 1'b0;
  logic       sdaLine;
  logic       dutLow;
  logic [3:0] pins = 4'b1010;
  logic       alert = 1'b0;
  logic [7:0] intStat = 8'h5E;
  logic [7:0] regAddr, regWdata, regRdata;
  logic       regWe, busLost;
  logic [7:0] mem [256];
  int         checks = 0;
  int         errors = 0;
  int         weCount = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  assign sdaLine = ~(sdaMlow | dutLow | extLow);

  pse_i2c_target #(.FILT_LEN(FILT), .WD_CYCLES(WD)) u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDriveLow(dutLow), .devPins(pins), .alertActive(alert),
    .intStatus(intStat), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRdata(regRdata), .busLost(busLost)
  );

  function automatic logic [7:0] initVal(input int a);
    return 8'((a * 5 + 17) % 256);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) mem[i] <= initVal(i);
    end else if (regWe) begin
      mem[regAddr] <= regWdata;
      weCount <= weCount + 1;
    end
  end
  assign regRdata = mem[regAddr];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic bitOutG(input logic b, input bit gScl, input bit gSda, output logic seen);
    sdaMlow = !b;
    tick(Q / 2);
    if (gScl) begin sclM = 1'b1; tick(2); sclM = 1'b0; end
    tick(Q / 2);
    sclM = 1'b1;
    tick(Q / 2);
    if (gSda) begin sdaMlow = 1'b1; tick(2); sdaMlow = !b; end
    tick(Q / 2);
    seen = sdaLine;
    sclM = 1'b0;
    tick(Q);
  endtask

  task automatic bitOut(input logic b, output logic seen);
    bitOutG(b, 1'b0, 1'b0, seen);
  endtask

  task automatic busStart();
    sdaMlow = 1'b1; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic busRestart();
    sdaMlow = 1'b0; tick(Q); sclM = 1'b1; tick(Q);
    sdaMlow = 1'b1; tick(Q); sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaMlow = 1'b1; tick(Q); sclM = 1'b1; tick(Q); sdaMlow = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bitOut(d[i], s);
    bitOut(1'b1, s);
    ack = !s;
  endtask

  task automatic recvByte(input bit mAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bitOut(1'b1, s);
      d[i] = s;
    end
    bitOut(!mAck, s);
  endtask

  initial begin : watchdogProc
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin : mainProc
    logic       ack;
    logic       s;
    logic [7:0] d;
    int         we0;

    tick(5);
    chkEq("R10 sda released in reset", 32'(dutLow), 0);
    chkEq("R10 no write in reset", 32'(regWe), 0);
    chkEq("R10 busLost clear", 32'(busLost), 0);
    rstN = 1'b1;
    tick(10);
    chkEq("R10 sda released after reset", 32'(dutLow), 0);

    // R1 / R9: address match swept over every pin setting
    for (int p = 0; p < 16; p++) begin
      pins = 4'(p);
      busStart();
      sendByte({3'b010, 4'(p), 1'b0}, ack);
      chkEq("R1 own address acked", 32'(ack), 1);
      busStop();
      busStart();
      sendByte({3'b010, 4'(p) ^ (4'b1 << (p % 4)), 1'b0}, ack);
      chkEq("R9 pin mismatch ignored", 32'(ack), 0);
      busStop();
      busStart();
      sendByte({3'b011, 4'(p), 1'b0}, ack);
      chkEq("R9 prefix mismatch ignored", 32'(ack), 0);
      busStop();
    end
    pins = 4'b1010;

    // R2 / R3: write two bytes
    we0 = weCount;
    busStart();
    sendByte({3'b010, pins, 1'b0}, ack); chkEq("R2 addr ack", 32'(ack), 1);
    sendByte(8'h40, ack); chkEq("R2 pointer ack", 32'(ack), 1);
    sendByte(8'hA5, ack); chkEq("R2 data ack", 32'(ack), 1);
    sendByte(8'h3C, ack); chkEq("R3 second data ack", 32'(ack), 1);
    busStop();
    chkEq("R2 first byte written", 32'(mem[8'h40]), 32'h A5);
    chkEq("R3 auto-increment write", 32'(mem[8'h41]), 32'h3C);
    chkEq("R2 one strobe per byte", 32'(weCount - we0), 2);

    // R4 / R3: repeated start read of three bytes
    busStart();
    sendByte({3'b010, pins, 1'b0}, ack);
    sendByte(8'h40, ack);
    busRestart();
    sendByte({3'b010, pins, 1'b1}, ack); chkEq("R4 read addr ack", 32'(ack), 1);
    recvByte(1'b1, d); chkEq("R4 read at pointer", 32'(d), 32'hA5);
    recvByte(1'b1, d); chkEq("R3 read increment", 32'(d), 32'h3C);
    recvByte(1'b0, d); chkEq("R3 read untouched reg", 32'(d), 32'(initVal(8'h42)));
    busStop();

    // R5: short-form read
    busStart();
    sendByte({3'b010, pins, 1'b1}, ack); chkEq("R5 short read ack", 32'(ack), 1);
    recvByte(1'b1, d); chkEq("R5 interrupt byte", 32'(d), 32'(intStat));
    recvByte(1'b0, d); chkEq("R5 interrupt byte repeated", 32'(d), 32'(intStat));
    busStop();
    busStart();
    sendByte({3'b010, pins, 1'b0}, ack);
    sendByte(8'h10, ack);
    busStop();
    intStat = 8'hC3;
    busStart();
    sendByte({3'b010, pins, 1'b1}, ack);
    recvByte(1'b0, d); chkEq("R5 stop discards pointer", 32'(d), 32'hC3);
    busStop();

    // R9: foreign write leaves registers alone
    we0 = weCount;
    busStart();
    sendByte({3'b010, pins ^ 4'b0001, 1'b0}, ack);
    sendByte(8'h40, ack);
    sendByte(8'h00, ack);
    chkEq("R9 data not acked", 32'(ack), 0);
    busStop();
    chkEq("R9 no strobe", 32'(weCount - we0), 0);
    chkEq("R9 register intact", 32'(mem[8'h40]), 32'hA5);

    // R6: alert response
    alert = 1'b1;
    busStart();
    sendByte(8'h19, ack); chkEq("R6 alert address acked", 32'(ack), 1);
    recvByte(1'b0, d); chkEq("R6 own address returned", 32'(d), 32'({3'b010, pins, 1'b1}));
    busStop();
    alert = 1'b0;
    busStart();
    sendByte(8'h19, ack); chkEq("R6 ignored without alert", 32'(ack), 0);
    busStop();

    // R7: lose arbitration on bit 6 (own bit 1, other device drives 0)
    alert = 1'b1;
    busStart();
    sendByte(8'h19, ack);
    for (int i = 7; i >= 0; i--) begin
      extLow = (i == 6);
      bitOut(1'b1, s);
      extLow = 1'b0;
      d[i] = s;
    end
    bitOut(1'b1, s);
    chkEq("R7 released after loss", 32'(d), 32'h3F);
    busStop();
    alert = 1'b0;

    // R11: glitches on both lines inside a data byte
    busStart();
    sendByte({3'b010, pins, 1'b0}, ack);
    sendByte(8'h60, ack);
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] gd;
      gd = 8'h81;
      bitOutG(gd[i], i == 5, i == 7, s);
    end
    bitOut(1'b1, s);
    chkEq("R11 byte acked despite glitch", 32'(!s), 1);
    busStop();
    chkEq("R11 data intact", 32'(mem[8'h60]), 32'h81);

    // R8: stall with SCL high during the target's acknowledge
    busStart();
    for (int i = 7; i >= 0; i--) begin
      logic [7:0] ad;
      ad = {3'b010, pins, 1'b0};
      bitOut(ad[i], s);
    end
    sdaMlow = 1'b0; tick(Q); sclM = 1'b1; tick(Q);
    chkEq("R8 ack held before stall", 32'(sdaLine), 0);
    tick(WD + 100);
    chkEq("R8 sda released", 32'(dutLow), 0);
    chkEq("R8 busLost set", 32'(busLost), 1);
    busStart();
    sendByte({3'b010, pins, 1'b0}, ack);
    chkEq("R8 recovered to idle", 32'(ack), 1);
    busStop();
    chkEq("R8 busLost sticky", 32'(busLost), 1);

    finishRun();
  end
endmodule